// File: doc/BRIEF.md
# Serial Configuration Loader for a Rack of Target Boards

This block sits on a master board and lets a processor load bitstreams, one bit per clock, into a set of programmable targets spread across several slave boards. Software first writes a selection byte that picks a board and a target device on it, or every board or every device at once. Software then writes a data/clock byte over and over. Its top bit is the shared configuration clock, and the seven low bits carry one serial data bit per device slot. Each target latches its bit on a rising clock edge. Software makes that edge by writing the clock bit low and then high.

While a load runs, the block watches two shared open-collector lines. An error line (active low) means a frame error, and the load must stop. A completion line goes high when the targets have finished. Both lines are synchronised to the local clock before use. A counter of rising configuration-clock edges lets software see how far a load has got. The counter also shows whether completion came before the expected number of bits. Selection codes that name no existing board or device are refused and recorded.

Top module: `cfg_load_master`

## Requirements
- R1: The board field is selection bits 3:0. Code 0 drives `board_sel` to all zeros. A code n from 1 to NB sets only bit n-1. Codes 14 and 15 set every bit.
- R2: The device field is selection bits 7:4. Code 0 drives `dev_sel` to all zeros. A code n from 1 to ND sets only bit n-1. Code 15 sets every bit.
- R3: Code 14 in either field raises `dev_reset` whenever the board field is not 0, and `dev_sel` then stays all zeros. Code 14 in the board field applies the reset to every board.
- R4: A selection write with a board code from NB+1 to 13, or a device code from ND+1 to 13, leaves the selection and all outputs unchanged. It sets the illegal flag (status bit 4), which stays set until reset.
- R5: A write to the data/clock register (address 1) shows on the outputs one cycle later: bit 7 drives `cfg_clk` and bits 6:0 drive `cfg_data`. The register reads back at address 1.
- R6: While a load is busy, each data/clock write that takes bit 7 from 0 to 1 adds one to the edge counter. The counter reads at addresses 3, 4 and 5, least significant byte first. A write that keeps bit 7 high does not count.
- R7: If the synchronised error line is low while a load is busy, the block sets the sticky abort flag (status bit 1) and clears busy. It also forces `cfg_clk` low. After that, data/clock writes are ignored until the next selection write.
- R8: If the synchronised completion line is high while a load is busy, the block sets complete (status bit 2) and clears busy. It sets early (status bit 3) when the counter is below BITS at that moment.
- R9: Status reads at address 2. A legal selection write starts a load, sets busy (status bit 0) and clears the counter and the abort, complete and early flags. A load needs a board code of 1 to NB or 15, and a device code of 1 to ND or 15.
- R10: After reset, every output is low, the status byte is 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | write address (0 selection, 1 data/clock) |
| wr_data | input | 8 | write data |
| rd_addr | input | 3 | read address |
| rd_data | output | 8 | read data, combinational |
| board_sel | output | NB | per-board select lines |
| dev_sel | output | ND | per-device select lines |
| dev_reset | output | 1 | reset request to the selected boards' devices |
| cfg_clk | output | 1 | shared configuration clock |
| cfg_data | output | ND | one serial data bit per device slot |
| init_n | input | 1 | shared frame-error line, active low |
| done | input | 1 | shared completion line |

## Verification
The bench targets the codes at the edges of each field: 0, NB, 15, 14 and the first refused codes. A decoder that is off by one would light the wrong select line, and one that accepts a refused code would change the selection. The bench repeats a clock-high write to catch a design that counts writes instead of rising edges. It raises completion both after the full bit count and after only three bits, to expose a wrong or missing early flag. Once an abort has happened it writes clock-high again. A design that does not lock out those writes would drive the clock again and keep counting, and a design whose abort is not sticky would show up when the next selection write is expected to clear it.

// File: rtl/cfg_load_master.sv
module cfg_load_master #(
  parameter int NB   = 9,
  parameter int ND   = 7,
  parameter int BITS = 247960
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [2:0]    rd_addr,
  output logic [7:0]    rd_data,
  output logic [NB-1:0] board_sel,
  output logic [ND-1:0] dev_sel,
  output logic          dev_reset,
  output logic          cfg_clk,
  output logic [ND-1:0] cfg_data,
  input  logic          init_n,
  input  logic          done
);
  localparam int CW = $clog2(BITS + 1);

  logic [7:0]    sel_q, dc_q;
  logic [CW-1:0] cnt;
  logic          busy, abort, cmpl, early, ill;
  logic [1:0]    init_sy, done_sy;

  wire [3:0] bf = sel_q[3:0];
  wire [3:0] df = sel_q[7:4];
  wire [3:0] wb = wr_data[3:0];
  wire [3:0] wd = wr_data[7:4];

  wire w_sel = wr_en && wr_addr == 3'd0;
  wire w_dc  = wr_en && wr_addr == 3'd1;
  wire w_bad = (int'(wb) > NB && wb < 4'd14) || (int'(wd) > ND && wd < 4'd14);
  wire w_load = wb != 4'd0 && wb != 4'd14 && wd != 4'd0 && wd != 4'd14;

  assign dev_reset = (df == 4'd14 || bf == 4'd14) && bf != 4'd0;

  for (genvar i = 0; i < NB; i++) begin : g_board
    assign board_sel[i] = (bf == 4'(i + 1)) || bf >= 4'd14;
  end
  for (genvar i = 0; i < ND; i++) begin : g_dev
    assign dev_sel[i] = !dev_reset && ((df == 4'(i + 1)) || df == 4'd15);
  end

  assign cfg_clk  = dc_q[7];
  assign cfg_data = dc_q[ND-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      init_sy <= 2'b11;
      done_sy <= 2'b00;
    end else begin
      init_sy <= {init_sy[0], init_n};
      done_sy <= {done_sy[0], done};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0; dc_q <= '0; cnt <= '0;
      busy <= 1'b0; abort <= 1'b0; cmpl <= 1'b0; early <= 1'b0; ill <= 1'b0;
    end else begin
      if (w_dc && !abort) begin
        dc_q <= wr_data;
        if (busy && wr_data[7] && !dc_q[7] && cnt != '1)
          cnt <= cnt + 1'b1;
      end
      if (w_sel) begin
        if (w_bad) ill <= 1'b1;
        else begin
          sel_q <= wr_data;
          busy  <= w_load;
          abort <= 1'b0;
          cmpl  <= 1'b0;
          early <= 1'b0;
          cnt   <= '0;
        end
      end else if (busy && !init_sy[1]) begin
        abort   <= 1'b1;
        busy    <= 1'b0;
        dc_q[7] <= 1'b0;
      end else if (busy && done_sy[1]) begin
        cmpl  <= 1'b1;
        busy  <= 1'b0;
        early <= cnt < CW'(BITS);
      end
    end

  wire [23:0] cnt_x = 24'(cnt);

  always_comb
    case (rd_addr)
      3'd0:    rd_data = sel_q;
      3'd1:    rd_data = dc_q;
      3'd2:    rd_data = {3'b000, ill, early, cmpl, abort, busy};
      3'd3:    rd_data = cnt_x[7:0];
      3'd4:    rd_data = cnt_x[15:8];
      3'd5:    rd_data = cnt_x[23:16];
      default: rd_data = 8'h00;
    endcase
endmodule

module cfg_load_master_chk #(
  parameter int NB = 9,
  parameter int ND = 7,
  parameter int CW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] board_sel,
  input logic [ND-1:0] dev_sel,
  input logic          dev_reset,
  input logic          cfg_clk,
  input logic          busy,
  input logic          abort,
  input logic          cmpl,
  input logic          ill,
  input logic [CW-1:0] cnt
);
  p_board_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(board_sel) <= 1) || (board_sel == '1));

  p_reset_no_dev_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> dev_sel == '0);

  p_ill_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ill |=> ill);

  p_idle_no_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (cnt == $past(cnt) || cnt == '0));

  p_abort_clk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !cfg_clk);

  p_abort_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort ##1 abort |-> $stable(cnt));

  p_busy_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(abort || cmpl));
endmodule

bind cfg_load_master cfg_load_master_chk #(.NB(NB), .ND(ND), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .board_sel(board_sel), .dev_sel(dev_sel),
  .dev_reset(dev_reset), .cfg_clk(cfg_clk), .busy(busy), .abort(abort),
  .cmpl(cmpl), .ill(ill), .cnt(cnt)
);

// File: tb/cfg_load_master_test.sv
module cfg_load_master_test;
  localparam int CLK = 10;
  localparam int NB = 9, ND = 7, BITS = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, init_n = 1, done = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [NB-1:0] board_sel;
  logic [ND-1:0] dev_sel, cfg_data;
  logic dev_reset, cfg_clk;
  int checks = 0, errors = 0;
  bit finished = 0;

  cfg_load_master #(.NB(NB), .ND(ND), .BITS(BITS)) uut (.*);

  always #(CLK/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1 d = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin
      wr(3'd1, 8'h00); wr(3'd1, 8'h81);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R10 board_sel", board_sel, 0);
    chk("R10 dev_sel", dev_sel, 0);
    chk("R10 clk/data/reset", {dev_reset, cfg_clk, cfg_data}, 0);
    rd(3'd2, v); chk("R10 status", v, 0);
    rd(3'd3, v); chk("R10 count", v, 0);
  endtask

  task automatic t_board;
    wr(3'd0, 8'h01); chk("R1 board 1", board_sel, 9'h001);
    wr(3'd0, 8'h09); chk("R1 board 9", board_sel, 9'h100);
    wr(3'd0, 8'h0F); chk("R1 board all", board_sel, 9'h1FF);
    wr(3'd0, 8'h00); chk("R1 board none", board_sel, 0);
  endtask

  task automatic t_dev;
    logic [7:0] v;
    wr(3'd0, 8'h12); chk("R2 dev 1", dev_sel, 7'h01);
    rd(3'd2, v); chk("R9 busy on load", v, 8'h01);
    wr(3'd0, 8'h72); chk("R2 dev 7", dev_sel, 7'h40);
    wr(3'd0, 8'hF2); chk("R2 dev all", dev_sel, 7'h7F);
    wr(3'd0, 8'h02); chk("R2 dev none", dev_sel, 0);
  endtask

  task automatic t_rstcode;
    logic [7:0] v;
    wr(3'd0, 8'hE3);
    chk("R3 dev reset", dev_reset, 1);
    chk("R3 dev_sel off", dev_sel, 0);
    chk("R3 board 3", board_sel, 9'h004);
    rd(3'd2, v); chk("R3 not busy", v, 0);
    wr(3'd0, 8'h5E);
    chk("R3 board-field reset", {dev_reset, board_sel}, {1'b1, 9'h1FF});
    chk("R3 dev_sel off 2", dev_sel, 0);
  endtask

  task automatic t_data;
    logic [7:0] v;
    wr(3'd0, 8'h21);
    wr(3'd1, 8'h55);
    chk("R5 clk", cfg_clk, 0);
    chk("R5 data", cfg_data, 7'h55);
    rd(3'd1, v); chk("R5 readback", v, 8'h55);
  endtask

  task automatic t_full;
    logic [7:0] v;
    wr(3'd0, 8'h11);
    edges(BITS);
    wr(3'd1, 8'h81);
    rd(3'd3, v); chk("R6 edge count", v, BITS);
    done = 1; idle(4);
    rd(3'd2, v); chk("R8 complete on time", v, 8'h04);
    done = 0; idle(3);
  endtask

  task automatic t_early;
    logic [7:0] v;
    wr(3'd0, 8'h11);
    rd(3'd3, v); chk("R9 count cleared", v, 0);
    edges(3);
    done = 1; idle(4);
    rd(3'd2, v); chk("R8 early complete", v, 8'h0C);
    rd(3'd3, v); chk("R6 count 3", v, 3);
    done = 0; idle(3);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    wr(3'd0, 8'h11);
    edges(2);
    chk("R5 clk high", cfg_clk, 1);
    init_n = 0; idle(4);
    rd(3'd2, v); chk("R7 abort", v, 8'h02);
    chk("R7 clk forced low", cfg_clk, 0);
    wr(3'd1, 8'h00); wr(3'd1, 8'h81);
    chk("R7 write ignored clk", cfg_clk, 0);
    rd(3'd3, v); chk("R7 count frozen", v, 2);
    init_n = 1; idle(3);
    wr(3'd0, 8'h11);
    rd(3'd2, v); chk("R9 restart clears abort", v, 8'h01);
    rd(3'd3, v); chk("R9 restart count", v, 0);
  endtask

  task automatic t_illegal;
    logic [7:0] v;
    wr(3'd0, 8'h11);
    wr(3'd0, 8'h1A);
    chk("R4 board 10 ignored", board_sel, 9'h001);
    rd(3'd0, v); chk("R4 select kept", v, 8'h11);
    rd(3'd2, v); chk("R4 flag set", v, 8'h11);
    wr(3'd0, 8'h81);
    chk("R4 dev 8 ignored", dev_sel, 7'h01);
    wr(3'd0, 8'h12);
    chk("R4 legal after", board_sel, 9'h002);
    rd(3'd2, v); chk("R4 flag sticky", v, 8'h11);
  endtask

  initial begin
    #(CLK * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    t_reset;
    t_board;
    t_dev;
    t_rstcode;
    t_data;
    t_full;
    t_early;
    t_abort;
    t_illegal;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule